// File: doc/BRIEF.md
# Serial GPIO Shift Engine

This block extends a chip's general-purpose signals over four wires: a serial clock, a serial data output, a serial data input and a one-cycle load strobe. Up to 80 output values held in a parallel register are sent out serially each frame. The same number of input values are captured from the remote shift-register chain and presented as a parallel vector. An external chain of shift registers (parallel-load on the strobe, shift on the clock) sits on the other side.

A single 32-bit control word configures the engine. Bit 0 is the run enable. Bits 9:6 give the frame length in groups of eight pins. Bits 31:16 give the divider value N, which sets the serial clock period to 2×(N+1) bus clocks. Frames repeat back to back while the engine is enabled. A new control word is applied only at the boundary between frames, so a frame in flight is never altered. The output vector is written through its own write strobe and is sampled once per frame.

Top module: `sgpio_engine`

## Requirements
- R1: During and after reset, sclk_o, sdo_o and sld_o are low and in_val_o is all zeros.
- R2: While shifting, sclk_o has a period of 2×(N+1) bus clocks and stays high for N+1 of them, where N is control bits 31:16.
- R3: Each frame begins with sld_o high for exactly one clock. The output vector is sampled in that cycle, and a write to the output vector later in the frame does not change the bits of that frame.
- R4: Bits are sent least significant first. sdo_o changes only when sclk_o falls or when a frame is loaded. sdi_i is sampled at the clock edge where sclk_o rises.
- R5: in_val_o changes only at the end of a frame, with all bits updated together. Bits at or above the frame length read as zero.
- R6: A frame carries 8×G bits, where G is control bits 9:6. Values of G above 10 act as 10, giving 80 bits.
- R7: A control word written during a frame takes effect only from the next frame onward.
- R8: While enabled, frames follow each other without gaps. The distance between load strobes is 1 + 2×(N+1)×(8×G) clocks.
- R9: Clearing the enable (control bit 0) lets the current frame finish. After that, sclk_o stays low, no load strobe occurs and in_val_o holds its value.
- R10: With the enable set and G equal to 0, no frame starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Control word write strobe |
| cfg_wdata_i | input | 32 | Control word: bit 0 enable, 9:6 groups, 31:16 divider |
| out_we_i | input | 1 | Output vector write strobe |
| out_wdata_i | input | 80 | Output vector value, bit i goes out as serial bit i |
| sdi_i | input | 1 | Serial data from the remote chain |
| sclk_o | output | 1 | Serial clock |
| sdo_o | output | 1 | Serial data to the remote chain |
| sld_o | output | 1 | One-cycle load strobe at frame start |
| in_val_o | output | 80 | Parallel input values from the last complete frame |

## Verification
The bench models the remote chain from the serial pins. It measures clock high time and period at N of 0, 1, 2 and 3; a divider off by one shows up as a wrong period. It changes the control word and the output vector in the middle of a frame. A design that applies them at once would produce a frame of the wrong length or mixed data. It runs an 80-bit frame followed by an 8-bit one and checks that stale upper input bits are cleared. It also covers a group count above ten, which an unclamped design would overrun, and disable in mid-frame, where the engine must finish the frame and then go quiet with its inputs held.

// File: rtl/sgpio_pkg.sv
package sgpio_pkg;
  localparam int unsigned EN_BIT  = 0;
  localparam int unsigned GRP_LSB = 6;
  localparam int unsigned GRP_W   = 4;
  localparam int unsigned DIV_LSB = 16;
  localparam int unsigned DIV_W   = 16;

  typedef struct packed {
    logic [DIV_W-1:0] div;
    logic [GRP_W-1:0] grp;
    logic             en;
  } sg_cfg_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOAD  = 2'd1,
    ST_SHIFT = 2'd2
  } sg_state_e;

  function automatic sg_cfg_t cfg_unpack(input logic [31:0] w);
    sg_cfg_t c;
    c.en  = w[EN_BIT];
    c.grp = w[GRP_LSB +: GRP_W];
    c.div = w[DIV_LSB +: DIV_W];
    return c;
  endfunction
endpackage

// File: rtl/sgpio_clkdiv.sv
module sgpio_clkdiv
  import sgpio_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             sclk_o,
  output logic             rise_o,
  output logic             fall_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             tick;

  assign tick   = run_i && (cnt_q == div_i);
  assign rise_o = tick && !sclk_o;
  assign fall_o = tick && sclk_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sclk_o <= 1'b0;
    end else if (!run_i) begin
      cnt_q  <= '0;
      sclk_o <= 1'b0;
    end else if (tick) begin
      cnt_q  <= '0;
      sclk_o <= ~sclk_o;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  // R2: half-period counter never passes the divider value
  a_r2_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_q <= div_i));
  // R2: clock parks low whenever not shifting
  a_r2_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !sclk_o);
endmodule

// File: rtl/sgpio_ctrl.sv
module sgpio_ctrl
  import sgpio_pkg::*;
#(
  parameter int unsigned MAX_GROUPS = 10,
  parameter int unsigned CNT_W      = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [31:0]      cfg_wdata_i,
  input  logic             fall_i,
  output logic             load_o,
  output logic             run_o,
  output logic             frame_end_o,
  output logic [CNT_W-1:0] bit_idx_o,
  output logic [DIV_W-1:0] div_o,
  output logic [CNT_W-1:0] npins_o
);
  sg_cfg_t        pend_q, pend_n, act_q;
  sg_state_e      state_q, state_d;
  logic [CNT_W-1:0] bit_q;
  logic [GRP_W-1:0] grp_c;
  logic           boundary, go;

  assign pend_n = cfg_we_i ? cfg_unpack(cfg_wdata_i) : pend_q;
  assign grp_c  = (act_q.grp > GRP_W'(MAX_GROUPS)) ? GRP_W'(MAX_GROUPS) : act_q.grp;
  assign npins_o = CNT_W'(grp_c) << 3;
  assign div_o   = act_q.div;

  assign load_o      = (state_q == ST_LOAD);
  assign run_o       = (state_q == ST_SHIFT);
  assign bit_idx_o   = bit_q;
  assign frame_end_o = run_o && fall_i && (bit_q == npins_o - 1'b1);
  assign boundary    = (state_q == ST_IDLE) || frame_end_o;
  assign go          = pend_n.en && (pend_n.grp != '0);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  state_d = go ? ST_LOAD : ST_IDLE;
      ST_LOAD:  state_d = ST_SHIFT;
      ST_SHIFT: if (frame_end_o) state_d = go ? ST_LOAD : ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= '0;
      act_q   <= '0;
      state_q <= ST_IDLE;
      bit_q   <= '0;
    end else begin
      pend_q  <= pend_n;
      state_q <= state_d;
      if (boundary) act_q <= pend_n;
      if (load_o) bit_q <= '0;
      else if (run_o && fall_i) bit_q <= bit_q + 1'b1;
    end
  end

  // R6: bit index stays inside the frame
  a_r6_bit_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_o |-> (bit_idx_o < npins_o));
  // R7: settings frozen while a frame is in flight
  a_r7_cfg_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_o && !frame_end_o) |=> ($stable(npins_o) && $stable(div_o)));
  // R3: load is followed by shifting
  a_r3_load_then_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> run_o);
endmodule

// File: rtl/sgpio_shifter.sv
module sgpio_shifter #(
  parameter int unsigned PINS  = 80,
  parameter int unsigned CNT_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             out_we_i,
  input  logic [PINS-1:0]  out_wdata_i,
  input  logic             load_i,
  input  logic             rise_i,
  input  logic             fall_i,
  input  logic             frame_end_i,
  input  logic [CNT_W-1:0] bit_idx_i,
  input  logic [CNT_W-1:0] npins_i,
  input  logic             sdi_i,
  output logic             sdo_o,
  output logic [PINS-1:0]  in_val_o
);
  logic [PINS-1:0] out_q, sh_q, cap_q, keep;

  always_comb begin
    for (int i = 0; i < PINS; i++) keep[i] = (CNT_W'(i) < npins_i);
  end

  assign sdo_o = sh_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q    <= '0;
      sh_q     <= '0;
      cap_q    <= '0;
      in_val_o <= '0;
    end else begin
      if (out_we_i) out_q <= out_wdata_i;
      if (load_i) sh_q <= out_q;
      else if (fall_i) sh_q <= {1'b0, sh_q[PINS-1:1]};
      if (rise_i) cap_q[bit_idx_i] <= sdi_i;
      if (frame_end_i) in_val_o <= cap_q & keep;
    end
  end

  // R4: serial output only moves on a falling clock or a load
  a_r4_sdo_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(load_i || fall_i) |=> $stable(sdo_o));
  // R5: parallel inputs only change at a frame end
  a_r5_in_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_end_i |=> $stable(in_val_o));
endmodule

// File: rtl/sgpio_engine.sv
module sgpio_engine
  import sgpio_pkg::*;
#(
  parameter int unsigned MAX_GROUPS = 10,
  localparam int unsigned PINS = MAX_GROUPS * 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cfg_we_i,
  input  logic [31:0]     cfg_wdata_i,
  input  logic            out_we_i,
  input  logic [PINS-1:0] out_wdata_i,
  input  logic            sdi_i,
  output logic            sclk_o,
  output logic            sdo_o,
  output logic            sld_o,
  output logic [PINS-1:0] in_val_o
);
  localparam int unsigned CNT_W = $clog2(PINS + 1);

  logic             load, run, frame_end, rise, fall;
  logic [CNT_W-1:0] bit_idx, npins;
  logic [DIV_W-1:0] div;

  sgpio_ctrl #(.MAX_GROUPS(MAX_GROUPS), .CNT_W(CNT_W)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .cfg_wdata_i(cfg_wdata_i),
    .fall_i(fall), .load_o(load), .run_o(run), .frame_end_o(frame_end),
    .bit_idx_o(bit_idx), .div_o(div), .npins_o(npins)
  );

  sgpio_clkdiv u_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run), .div_i(div),
    .sclk_o(sclk_o), .rise_o(rise), .fall_o(fall)
  );

  sgpio_shifter #(.PINS(PINS), .CNT_W(CNT_W)) u_shift (
    .clk_i(clk_i), .rst_ni(rst_ni), .out_we_i(out_we_i), .out_wdata_i(out_wdata_i),
    .load_i(load), .rise_i(rise), .fall_i(fall), .frame_end_i(frame_end),
    .bit_idx_i(bit_idx), .npins_i(npins), .sdi_i(sdi_i),
    .sdo_o(sdo_o), .in_val_o(in_val_o)
  );

  assign sld_o = load;

  // R3: strobe lasts one clock and the serial clock is low with it
  a_r3_ld_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sld_o |=> (!sld_o && !sclk_o));
endmodule

// File: tb/tb_sgpio_engine.sv
`timescale 1ns/1ps
module tb_sgpio_engine;
  localparam int P = 80;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0, out_we = 1'b0, sdi = 1'b0;
  logic [31:0] cfg_wd = '0;
  logic [P-1:0] out_wd = '0;
  wire sclk, sdo, sld;
  wire [P-1:0] in_val;

  always #2.5 clk = ~clk;

  sgpio_engine dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wd),
    .out_we_i(out_we), .out_wdata_i(out_wd), .sdi_i(sdi),
    .sclk_o(sclk), .sdo_o(sdo), .sld_o(sld), .in_val_o(in_val)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // remote chain model
  logic [P-1:0] rem = '0, rx = '0, rx_last = '0;
  int frames = 0, bits_last = 0, nrise = 0, bitidx = 0, gap = 0, high = 0;
  int cyc = 0, last_rise = 0, hi_start = 0, sld_seen = 0, last_sld = 0, sld_gap = 0, sld_len = 0;
  bit running = 0, sclk_prev = 0, sld_prev = 0;

  always @(negedge clk) begin
    cyc++;
    if (sld === 1'b1 && !sld_prev) begin
      if (sld_seen > 0) sld_gap = cyc - last_sld;
      last_sld = cyc; sld_seen++; sld_len = 1;
      if (running) begin frames++; rx_last = rx; bits_last = nrise; end
      running = 1; nrise = 0; bitidx = 0; rx = '0; sdi = rem[0];
    end else if (sld === 1'b1) begin
      sld_len++;
    end else begin
      if (sclk === 1'b1 && !sclk_prev) begin
        if (nrise < P) rx[nrise] = sdo;
        if (nrise > 0) gap = cyc - last_rise;
        last_rise = cyc; hi_start = cyc; nrise++;
      end
      if (sclk === 1'b0 && sclk_prev) begin
        high = cyc - hi_start; bitidx++;
        if (bitidx < P) sdi = rem[bitidx];
      end
    end
    sclk_prev = (sclk === 1'b1);
    sld_prev  = (sld === 1'b1);
  end

  function automatic logic [P-1:0] mask_of(input int n);
    logic [P-1:0] m = '0;
    for (int i = 0; i < P; i++) m[i] = (i < n);
    return m;
  endfunction

  task automatic check(input bit ok, input string req, input logic [P-1:0] act, input logic [P-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input bit en, input logic [3:0] grp, input logic [15:0] dv);
    cfg_wd = {dv, 6'b0, grp, 5'b0, en};
    cfg_we = 1'b1;
    @(posedge clk); #1 cfg_we = 1'b0;
  endtask

  task automatic out_write(input logic [P-1:0] v);
    out_wd = v; out_we = 1'b1;
    @(posedge clk); #1 out_we = 1'b0;
  endtask

  task automatic wait_frames(input int n);
    int tgt = frames + n;
    int lim = 0;
    while (frames < tgt && lim < 20000) begin @(negedge clk); #1; lim++; end
    check(frames >= tgt, "wait_frames", P'(frames), P'(tgt));
  endtask

  task automatic sync_load();
    int lim = 0;
    while (sld !== 1'b1 && lim < 20000) begin @(negedge clk); #1; lim++; end
  endtask

  task automatic t_reset();
    repeat (3) @(posedge clk);
    #1;
    check(sclk === 1'b0 && sdo === 1'b0 && sld === 1'b0, "R1 pins", P'({sclk, sdo, sld}), '0);
    check(in_val === '0, "R1 in_val", in_val, '0);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    check(sld_seen == 0, "R1 idle after reset", P'(sld_seen), '0);
  endtask

  task automatic t_basic();
    logic [P-1:0] o = 80'h0123_4567_89AB_CDEF_A5C3;
    rem = 80'hFFFF_0000_1111_2222_3C5A;
    out_write(o);
    cfg_write(1'b1, 4'd2, 16'd1);
    wait_frames(2);
    check(rx_last[15:0] === o[15:0], "R4 lsb-first data", rx_last & mask_of(16), o & mask_of(16));
    check(bits_last == 16, "R6 16-bit frame", P'(bits_last), P'(16));
    check(gap == 4, "R2 period N=1", P'(gap), P'(4));
    check(high == 2, "R2 high N=1", P'(high), P'(2));
    check(in_val === (rem & mask_of(16)), "R5 captured", in_val, rem & mask_of(16));
  endtask

  task automatic t_fast();
    logic [P-1:0] o = 80'h96;
    rem = 80'h69;
    out_write(o);
    cfg_write(1'b1, 4'd1, 16'd0);
    wait_frames(2);
    check(gap == 2, "R2 period N=0", P'(gap), P'(2));
    check(high == 1, "R2 high N=0", P'(high), P'(1));
    check(rx_last[7:0] === o[7:0], "R4 data N=0", rx_last & mask_of(8), o);
    check(in_val === rem, "R4 sample N=0", in_val, rem);
  endtask

  task automatic t_full();
    logic [P-1:0] o = 80'hDEAD_BEEF_CAFE_F00D_1234;
    rem = 80'h8001_7FFE_5555_AAAA_0F0F;
    out_write(o);
    cfg_write(1'b1, 4'd10, 16'd3);
    wait_frames(2);
    check(bits_last == 80, "R6 80-bit frame", P'(bits_last), P'(80));
    check(gap == 8, "R2 period N=3", P'(gap), P'(8));
    check(rx_last === o, "R4 80-bit data", rx_last, o);
    check(in_val === rem, "R5 80-bit capture", in_val, rem);
  endtask

  task automatic t_clamp_mask();
    rem = '1;
    cfg_write(1'b1, 4'd15, 16'd0);
    wait_frames(2);
    check(bits_last == 80, "R6 clamp", P'(bits_last), P'(80));
    check(in_val === '1, "R6 clamp capture", in_val, '1);
    cfg_write(1'b1, 4'd1, 16'd0);
    wait_frames(2);
    check(in_val === mask_of(8), "R5 upper bits cleared", in_val, mask_of(8));
  endtask

  task automatic t_boundary();
    sync_load();
    cfg_write(1'b1, 4'd3, 16'd0);
    wait_frames(1);
    check(bits_last == 8, "R7 current frame kept", P'(bits_last), P'(8));
    wait_frames(1);
    check(bits_last == 24, "R7 next frame new", P'(bits_last), P'(24));
  endtask

  task automatic t_out_sample();
    logic [P-1:0] a = 80'h3A, b = 80'hC5;
    cfg_write(1'b1, 4'd1, 16'd2);
    out_write(a);
    wait_frames(2);
    sync_load();
    @(negedge clk); #1;
    out_write(b);
    wait_frames(1);
    check(rx_last[7:0] === a[7:0], "R3 frame keeps sampled vector", rx_last & mask_of(8), a);
    check(sld_len == 1, "R3 strobe width", P'(sld_len), P'(1));
    check(sld_gap == 49, "R8 back-to-back period", P'(sld_gap), P'(49));
    wait_frames(1);
    check(rx_last[7:0] === b[7:0], "R3 next frame new vector", rx_last & mask_of(8), b);
  endtask

  task automatic t_disable();
    logic [P-1:0] held;
    int seen;
    rem = 80'h5B;
    cfg_write(1'b1, 4'd1, 16'd0);
    wait_frames(2);
    sync_load();
    cfg_write(1'b0, 4'd1, 16'd0);
    repeat (60) @(negedge clk);
    #1;
    check(nrise == 8, "R9 frame completes", P'(nrise), P'(8));
    check(in_val === 80'h5B, "R9 last capture", in_val, 80'h5B);
    held = in_val; seen = sld_seen;
    rem = 80'hA4; sdi = 1'b1;
    repeat (100) @(negedge clk);
    #1;
    check(sld_seen == seen && sclk === 1'b0, "R9 quiet", P'(sld_seen), P'(seen));
    check(in_val === held, "R9 inputs held", in_val, held);
  endtask

  task automatic t_zero_groups();
    int seen = sld_seen;
    cfg_write(1'b1, 4'd0, 16'd0);
    repeat (100) @(negedge clk);
    #1;
    check(sld_seen == seen && sclk === 1'b0, "R10 no frame", P'(sld_seen), P'(seen));
  endtask

  initial begin
    t_reset();
    t_basic();
    t_fast();
    t_full();
    t_clamp_mask();
    t_boundary();
    t_out_sample();
    t_disable();
    t_zero_groups();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule